// File: doc/BRIEF.md
# Context Fetch Stage with Predict-Taken Branching

This block is the front end of a small context-driven processing element. It keeps a program counter (PC) that indexes a 32-entry local context store and presents the addressed context word to a downstream decoder in the same cycle. Each cycle it picks the following PC from three sources: the sequential address, a branch target supplied by the decoder, or a backup address saved when a branch was fetched. Every branch is treated as taken, so a loop body that jumps backwards repeats with no lost cycle. When a later stage reports that the prediction was wrong, the PC returns to the saved backup address and the context fetched on the wrong path is withheld.

The block runs a three-state controller. In `ST_CFG` the context store is loaded through a write port and the PC and backup register are cleared. Transition T_START moves it to `ST_RUN` once `cfg_mode` is low. In `ST_RUN` the PC steps, jumps, holds or rolls back. Transition T_END moves it to `ST_DONE` when an END context is fetched and no rollback is pending. In `ST_DONE` the PC is frozen and `done` is high. Transition T_RECFG returns to `ST_CFG` from `ST_RUN` or `ST_DONE` whenever `cfg_mode` is high.

Top module: `ctx_fetch`

## Requirements
- R1: During and right after reset, `pc` is 0, `done` is 0 and `ctx_valid` is 0, and the block is in the configuration state.
- R2: A write with `cfg_we` high stores `cfg_data` at `cfg_addr` only while the block is in the configuration state with `cfg_mode` high. A write issued in any other state leaves the store unchanged.
- R3: After `cfg_mode` falls, fetching starts one clock later at address 0. In the run state `ctx` shows the store entry at `pc` combinationally.
- R4: With no jump, stall, branch or rollback, `pc` advances by one each clock and wraps from 31 to 0.
- R5: With `jump` high and nothing of higher priority present, the next `pc` is `br_target`, so the branch is predicted taken.
- R6: `pc` holds while `stall` is high. It also holds while a conditional branch is presented (`br_detected` and `br_cond` high) and `br_ops_ok` is low.
- R7: The backup register captures `pc + 1` when `br_detected` is high, `br_invalid` is low, and either the branch is unconditional or `br_ops_ok` is high.
- R8: With `br_invalid` high in the run state, the next `pc` is the backup value, whatever the values of `jump` and `stall`. `ctx_valid` is low in that cycle.
- R9: A context whose opcode field, bits [31:28], equals 4'hF is END. Fetching it with no rollback freezes `pc` and raises `done` from the next clock. `done` stays high with `ctx_valid` low until `cfg_mode` is raised, and then it clears one clock later.
- R10: While `done` is high, `jump`, `br_invalid` and the other branch inputs have no effect on `pc`.
- R11: A rollback takes priority over an END fetched in the same cycle and over a branch capture in the same cycle. The PC returns to the old backup value, and that backup value stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | Requests or holds the configuration state |
| cfg_we | input | 1 | Write strobe for the context store |
| cfg_addr | input | 5 | Context store write address |
| cfg_data | input | 32 | Context word to write |
| stall | input | 1 | Back-pressure or missing-operand stall |
| jump | input | 1 | Decoder indicates a branch to be taken |
| br_invalid | input | 1 | An earlier predicted branch was wrong |
| br_detected | input | 1 | The current context is a branch |
| br_cond | input | 1 | The detected branch is conditional |
| br_ops_ok | input | 1 | The conditional branch operands are available |
| br_target | input | 5 | Branch target address from the context |
| pc | output | 5 | Current program counter |
| ctx | output | 32 | Context word at `pc` |
| ctx_valid | output | 1 | `ctx` may be issued by the decoder |
| done | output | 1 | END reached; the PC is frozen |

## Verification
A rollback can arrive in the same cycle as a new branch detection, or in the same cycle as an END fetch, because the wrong-path context is still on `ctx` when the misprediction is reported. The bench provokes the first case by raising `br_invalid`, `br_detected` and `jump` together. It then judges the result by a second rollback a few cycles later, which must land on the older backup address and prove that no capture happened. The second case is provoked by jumping onto the END entry and reporting a misprediction in that cycle. The bench expects `pc` to return to the backup address and `done` to stay low.

// File: rtl/cf_pkg.sv
package cf_pkg;
    typedef enum logic [1:0] {
        ST_CFG  = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } cf_state_e;

    localparam int OPC_W = 4;
    localparam logic [OPC_W-1:0] OPC_END = 4'hF;
endpackage

// File: rtl/cf_ctx_mem.sv
module cf_ctx_mem #(
    parameter int DEPTH = 32,
    parameter int CTX_W = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [CTX_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [CTX_W-1:0] rdata
);
    logic [CTX_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/cf_seq_fsm.sv
module cf_seq_fsm
    import cf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_mode,
    input  logic      end_hit,
    output cf_state_e state_o,
    output logic      is_cfg,
    output logic      is_run,
    output logic      is_done
);
    cf_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CFG;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_START, T_END, T_RECFG
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CFG:  if (!cfg_mode) state_d = ST_RUN;
            ST_RUN:  begin
                if (cfg_mode)     state_d = ST_CFG;
                else if (end_hit) state_d = ST_DONE;
            end
            ST_DONE: if (cfg_mode) state_d = ST_CFG;
            default: state_d = ST_CFG;
        endcase
    end

    // decoded outputs
    always_comb begin
        is_cfg  = 1'b0;
        is_run  = 1'b0;
        is_done = 1'b0;
        unique case (state_q)
            ST_CFG:  is_cfg  = 1'b1;
            ST_RUN:  is_run  = 1'b1;
            ST_DONE: is_done = 1'b1;
            default: is_cfg  = 1'b1;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/cf_pc_sel.sv
module cf_pc_sel #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          rollback,
    input  logic          freeze,
    input  logic          jump,
    input  logic [AW-1:0] target,
    input  logic          capture,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] bkp_o
);
    logic [AW-1:0] pc_q, bkp_q, pc_inc, pc_d;

    assign pc_inc = (pc_q == LAST) ? '0 : pc_q + 1'b1;

    // priority: rollback > freeze (END / stall) > predicted-taken > step
    always_comb begin
        if (rollback)    pc_d = bkp_q;
        else if (freeze) pc_d = pc_q;
        else if (jump)   pc_d = target;
        else             pc_d = pc_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            bkp_q <= '0;
        end else if (clear) begin
            pc_q  <= '0;
            bkp_q <= '0;
        end else if (run) begin
            pc_q <= pc_d;
            if (capture) begin
                bkp_q <= pc_inc;
            end
        end
    end

    assign pc_o  = pc_q;
    assign bkp_o = bkp_q;
endmodule

// File: rtl/ctx_fetch.sv
module ctx_fetch
    import cf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CTX_W = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [CTX_W-1:0] cfg_data,
    input  logic             stall,
    input  logic             jump,
    input  logic             br_invalid,
    input  logic             br_detected,
    input  logic             br_cond,
    input  logic             br_ops_ok,
    input  logic [AW-1:0]    br_target,
    output logic [AW-1:0]    pc,
    output logic [CTX_W-1:0] ctx,
    output logic             ctx_valid,
    output logic             done
);
    cf_state_e     state_q;
    logic          is_cfg, is_run, is_done;
    logic          is_end, cond_wait, hold, capture, end_hit;
    logic [AW-1:0] pc_q, bkp_q;

    assign is_end    = (ctx[CTX_W-1 -: OPC_W] == OPC_END);
    assign cond_wait = br_detected && br_cond && !br_ops_ok;
    assign hold      = stall || cond_wait || is_end;
    assign capture   = br_detected && !br_invalid && (!br_cond || br_ops_ok);
    assign end_hit   = is_end && !br_invalid;

    cf_ctx_mem #(.DEPTH(DEPTH), .CTX_W(CTX_W)) mem_i (
        .clk   (clk),
        .we    (cfg_we && cfg_mode && is_cfg),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .raddr (pc_q),
        .rdata (ctx)
    );

    cf_seq_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_mode (cfg_mode),
        .end_hit  (end_hit),
        .state_o  (state_q),
        .is_cfg   (is_cfg),
        .is_run   (is_run),
        .is_done  (is_done)
    );

    cf_pc_sel #(.DEPTH(DEPTH)) sel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (is_cfg),
        .run      (is_run),
        .rollback (br_invalid),
        .freeze   (hold),
        .jump     (jump),
        .target   (br_target),
        .capture  (capture),
        .pc_o     (pc_q),
        .bkp_o    (bkp_q)
    );

    assign pc        = pc_q;
    assign ctx_valid = is_run && !br_invalid;
    assign done      = is_done;
endmodule

// File: rtl/cf_fetch_chk.sv
module cf_fetch_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_mode,
    input logic          stall,
    input logic          jump,
    input logic          br_invalid,
    input logic          br_detected,
    input logic [AW-1:0] br_target,
    input logic [AW-1:0] pc,
    input logic          ctx_valid,
    input logic          done,
    input logic          run
);
    // R9
    done_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ctx_valid);

    // R8
    rollback_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && br_invalid) |-> !ctx_valid);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cfg_mode && stall && !br_invalid) |=> $stable(pc));

    // R5
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cfg_mode && jump && !stall && !br_invalid && !br_detected)
        |=> (done || pc == $past(br_target)));

    // R4
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cfg_mode && !jump && !stall && !br_invalid && !br_detected)
        |=> (done || pc == AW'($past(pc) + 1'b1)));

    // R10
    done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_mode) |=> (done && $stable(pc)));
endmodule

bind ctx_fetch cf_fetch_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .stall       (stall),
    .jump        (jump),
    .br_invalid  (br_invalid),
    .br_detected (br_detected),
    .br_target   (br_target),
    .pc          (pc),
    .ctx_valid   (ctx_valid),
    .done        (done),
    .run         (is_run)
);

// File: tb/ctx_fetch_tb_top.sv
module ctx_fetch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mode = 1'b1, cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_data = '0;
    logic        stall = 0, jump = 0, br_invalid = 0, br_detected = 0, br_cond = 0, br_ops_ok = 0;
    logic [4:0]  br_target = '0;
    logic [4:0]  pc;
    logic [31:0] ctx;
    logic        ctx_valid, done;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    ctx_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .stall(stall), .jump(jump),
        .br_invalid(br_invalid), .br_detected(br_detected), .br_cond(br_cond),
        .br_ops_ok(br_ops_ok), .br_target(br_target), .pc(pc), .ctx(ctx),
        .ctx_valid(ctx_valid), .done(done)
    );

    function automatic logic [31:0] word_at(int i);
        return {(i == 20) ? 4'hF : 4'h1, 28'(i * 3 + 7)};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // {req, stall, jump, br_invalid, br_detected, br_cond, br_ops_ok, target, exp_pc, exp_done}
    localparam int NV = 20;
    localparam logic [20:0] VEC [NV] = '{
        {4'd4,  6'b000000, 5'd0,  5'd1,  1'b0},  // R4 step
        {4'd4,  6'b000000, 5'd0,  5'd2,  1'b0},  // R4 step
        {4'd6,  6'b100000, 5'd0,  5'd2,  1'b0},  // R6 stall
        {4'd7,  6'b010100, 5'd10, 5'd10, 1'b0},  // R5 R7 taken, backup=3
        {4'd4,  6'b000000, 5'd0,  5'd11, 1'b0},  // R4
        {4'd8,  6'b001000, 5'd0,  5'd3,  1'b0},  // R8 rollback to 3
        {4'd6,  6'b010110, 5'd25, 5'd3,  1'b0},  // R6 cond, operands missing
        {4'd7,  6'b010111, 5'd25, 5'd25, 1'b0},  // R7 cond taken, backup=4
        {4'd11, 6'b011100, 5'd8,  5'd4,  1'b0},  // R11 rollback beats capture
        {4'd4,  6'b000000, 5'd0,  5'd5,  1'b0},  // R4
        {4'd11, 6'b101000, 5'd0,  5'd4,  1'b0},  // R11 R8 backup still 4, stall ignored
        {4'd5,  6'b010000, 5'd30, 5'd30, 1'b0},  // R5
        {4'd4,  6'b000000, 5'd0,  5'd31, 1'b0},  // R4
        {4'd4,  6'b000000, 5'd0,  5'd0,  1'b0},  // R4 wrap
        {4'd7,  6'b010100, 5'd20, 5'd20, 1'b0},  // R7 backup=1
        {4'd11, 6'b001000, 5'd0,  5'd1,  1'b0},  // R11 rollback beats END
        {4'd5,  6'b010000, 5'd20, 5'd20, 1'b0},  // R5
        {4'd9,  6'b000000, 5'd0,  5'd20, 1'b1},  // R9 END
        {4'd10, 6'b010000, 5'd3,  5'd20, 1'b1},  // R10 jump ignored
        {4'd10, 6'b001000, 5'd0,  5'd20, 1'b1}   // R10 rollback ignored
    };

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired before the end of the test");
        summary();
    end

    initial begin
        logic [4:0] pc_m;
        logic       done_m;
        string      tag;

        // R1 reset state
        repeat (2) @(posedge clk);
        #1;
        chk(pc == 5'd0, "R1 pc", 32'(pc), 0);
        chk(done == 1'b0, "R1 done", 32'(done), 0);
        chk(ctx_valid == 1'b0, "R1 ctx_valid", 32'(ctx_valid), 0);
        @(negedge clk) rst_n = 1'b1;

        // R2 load while configuring
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_addr = 5'(i); cfg_data = word_at(i);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_mode = 1'b0;
        @(posedge clk); #1;
        // R3 fetch starts at 0
        chk(pc == 5'd0 && ctx_valid, "R3 start", {ctx_valid, 26'd0, pc}, 32'h8000_0000);
        chk(ctx == word_at(0), "R2 R3 word at 0", ctx, word_at(0));

        pc_m = 5'd0;
        done_m = 1'b0;
        for (int k = 0; k < NV; k++) begin
            logic [20:0] v;
            v = VEC[k];
            tag = $sformatf("R%0d row%0d", v[20:17], k);
            @(negedge clk);
            stall = v[16]; jump = v[15]; br_invalid = v[14];
            br_detected = v[13]; br_cond = v[12]; br_ops_ok = v[11];
            br_target = v[10:6];
            #1;
            chk(ctx_valid == (!v[14] && !done_m), {tag, " ctx_valid"},
                32'(ctx_valid), 32'(!v[14] && !done_m));
            if (!done_m) chk(ctx == word_at(int'(pc_m)), {tag, " ctx"}, ctx, word_at(int'(pc_m)));
            @(posedge clk); #1;
            chk(pc == v[5:1], {tag, " pc"}, 32'(pc), 32'(v[5:1]));
            chk(done == v[0], {tag, " done"}, 32'(done), 32'(v[0]));
            pc_m = v[5:1];
            done_m = v[0];
        end

        // R2 a write outside configuration is ignored
        @(negedge clk);
        stall = 0; jump = 0; br_invalid = 0; br_detected = 0; br_cond = 0; br_ops_ok = 0;
        cfg_we = 1'b1; cfg_addr = 5'd20; cfg_data = 32'h1234_5678;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_mode = 1'b1;
        @(posedge clk); #1;
        // R9 reconfiguration clears done
        chk(done == 1'b0, "R9 done cleared", 32'(done), 0);
        @(negedge clk) cfg_mode = 1'b0;
        @(posedge clk); #1;
        chk(pc == 5'd0 && ctx_valid, "R3 restart", {ctx_valid, 26'd0, pc}, 32'h8000_0000);
        @(negedge clk);
        jump = 1'b1; br_target = 5'd20;
        @(posedge clk); #1;
        chk(pc == 5'd20, "R5 jump to 20", 32'(pc), 20);
        chk(ctx == word_at(20), "R2 write ignored", ctx, word_at(20));
        @(negedge clk) jump = 1'b0;
        @(posedge clk); #1;
        chk(done == 1'b1 && pc == 5'd20, "R9 END again", {done, 26'd0, pc}, 32'h8000_0014);

        summary();
    end
endmodule